// File: doc/BRIEF.md
# Triggered Delay-and-Sample Sequencer

This block sequences one acquisition. It waits until it is armed, catches a trigger edge, counts a programmable coarse delay and then raises a sample strobe for a window of fixed length. A short post phase follows. The post phase clears the sample strobe and the armed flag, and it strobes a reload of the delay counter. In normal operation the sequencer stays idle after the post phase until the host sends a rearm pulse. In continuous-wave mode the sequencer rearms itself and keeps its triggered latch set, so acquisitions repeat without further trigger edges.

The delay counter counts upward from the loaded value and ends the delay on its terminal-count carry. A loaded value of all ones therefore gives the shortest possible delay. The trigger and rearm inputs are asynchronous and pass through a synchronizer. The block acts on their synchronized rising edges.

Top module: `tds_sequencer`

## Requirements
- R1: After reset, `ready_o` is 1 and `trig_o`, `sample_o`, `post_o` and `load_o` are all 0.
- R2: A synchronized rising edge on `trig_in` sets `trig_o` only while `ready_o` is 1 and the sequencer is idle. While `ready_o` is 0, a trigger edge leaves `trig_o` and `sample_o` at 0.
- R3: For a coarse value V on `delay_val`, `sample_o` rises exactly 2^20 − V clock cycles after `trig_o` rises. The value 0xFFFFF gives the shortest delay, which is 1 cycle.
- R4: The delay ends on a terminal-count carry that lasts a single clock. `sample_o` never rises in the same cycle as `trig_o` rises.
- R5: `sample_o` stays high for exactly 510 cycles. `post_o` rises in the same cycle that `sample_o` falls.
- R6: `post_o` stays high for exactly 4 cycles. `load_o` is high only during the first 2 of those cycles, so it is released 2 cycles before `post_o` falls.
- R7: While `post_o` is high, `ready_o` is 0. When the post phase ends, `sample_o` is 0. Outside continuous-wave mode, `trig_o` is also 0 when the post phase ends.
- R8: Outside continuous-wave mode, `ready_o` stays 0 after the post phase until a synchronized rising edge on `rearm_in` sets it to 1. No new acquisition starts before that edge.
- R9: With `cw_mode` = 1, `trig_o` stays 1 once set, and `ready_o` returns to 1 in the same cycle that `post_o` falls. The next `sample_o` rise follows the fall of `post_o` by 1 + (2^20 − V) cycles, with no trigger edge and no rearm pulse.
- R10: `sample_o` is high only while `trig_o` is high, and `sample_o` and `post_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Asynchronous trigger input |
| rearm_in | input | 1 | Asynchronous host rearm pulse |
| delay_val | input | 20 | Coarse delay start value; all ones means the shortest delay |
| cw_mode | input | 1 | Continuous-wave mode enable |
| ready_o | output | 1 | Armed flag |
| trig_o | output | 1 | Triggered latch |
| sample_o | output | 1 | Sample window strobe |
| post_o | output | 1 | Post phase |
| load_o | output | 1 | Coarse counter reload strobe |

## Verification
The hardest situation to reach is the free-running repeat in continuous-wave mode, followed by the return to normal mode. The bench enables the mode before a single trigger edge and measures the automatic restart against the fall of the post phase. It then clears the mode in the middle of a sample window, so that the next post phase must clear the triggered latch and leave the block disarmed. A trigger edge sent while the block is disarmed shows that a new acquisition waits for the rearm pulse.

// File: rtl/tds_pkg.sv
package tds_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_DELAY  = 2'd1,
      ST_SAMPLE = 2'd2,
      ST_POST   = 2'd3
   } tds_state_e;
endpackage

// File: rtl/tds_sync.sv
module tds_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tds_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      logic              prev;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
         end else begin
            chain <= {chain[STAGES-2:0], din[b]};
            prev  <= chain[STAGES-1];
         end
      end
      assign rise[b] = chain[STAGES-1] & ~prev;
   end
endmodule

// File: rtl/tds_coarse_ctr.sv
module tds_coarse_ctr #(
   parameter int W = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         en,
   output logic         carry
);
   if (W < 2) begin : g_bad_w
      $error("tds_coarse_ctr: W must be at least 2");
   end

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '1;
      else if (load) cnt <= load_val;
      else if (en)   cnt <= cnt + 1'b1;
   end

   assign carry = en & (&cnt);
endmodule

// File: rtl/tds_window.sv
module tds_window #(
   parameter int LEN = 510
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic last
);
   localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;

   if (LEN < 2) begin : g_bad_len
      $error("tds_window: LEN must be at least 2");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) cnt <= '0;
      else               cnt <= cnt + 1'b1;
   end

   assign last = en && (cnt == CW'(LEN - 1));
endmodule

// File: rtl/tds_sequencer.sv
module tds_sequencer
   import tds_pkg::*;
#(
   parameter int CNT_W       = 20,
   parameter int SAMPLE_LEN  = 510,
   parameter int POST_LEN    = 4,
   parameter int POST_LOAD   = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_in,
   input  logic             rearm_in,
   input  logic [CNT_W-1:0] delay_val,
   input  logic             cw_mode,
   output logic             ready_o,
   output logic             trig_o,
   output logic             sample_o,
   output logic             post_o,
   output logic             load_o
);
   localparam int PW = $clog2(POST_LEN + 1);

   if (POST_LOAD < 1 || POST_LOAD + 2 > POST_LEN) begin : g_bad_post
      $error("tds_sequencer: need 1 <= POST_LOAD <= POST_LEN - 2");
   end

   logic [1:0]  rise_v;
   logic        trig_edge, rearm_edge;
   logic        start, carry, win_last;
   tds_state_e  state;
   logic        ready_q, trig_q, samp_q, post_q;
   logic [PW-1:0] post_cnt;

   tds_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .din({rearm_in, trig_in}), .rise(rise_v)
   );
   assign trig_edge  = rise_v[0];
   assign rearm_edge = rise_v[1];

   assign start = (state == ST_IDLE) && ready_q && (trig_edge || (cw_mode && trig_q));

   tds_coarse_ctr #(.W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .load(load_o | start), .load_val(delay_val),
      .en(state == ST_DELAY), .carry(carry)
   );

   tds_window #(.LEN(SAMPLE_LEN)) u_win (
      .clk(clk), .rst_n(rst_n), .en(state == ST_SAMPLE), .last(win_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         ready_q  <= 1'b1;
         trig_q   <= 1'b0;
         samp_q   <= 1'b0;
         post_q   <= 1'b0;
         post_cnt <= '0;
      end else begin
         if (rearm_edge && state != ST_POST) ready_q <= 1'b1;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state  <= ST_DELAY;
                  trig_q <= 1'b1;
               end
            end
            ST_DELAY: begin
               if (carry) begin
                  state  <= ST_SAMPLE;
                  samp_q <= 1'b1;
               end
            end
            ST_SAMPLE: begin
               if (win_last) begin
                  state    <= ST_POST;
                  samp_q   <= 1'b0;
                  post_q   <= 1'b1;
                  ready_q  <= 1'b0;
                  post_cnt <= '0;
                  if (!cw_mode) trig_q <= 1'b0;
               end
            end
            default: begin
               post_cnt <= post_cnt + 1'b1;
               if (post_cnt == PW'(POST_LEN - 1)) begin
                  state   <= ST_IDLE;
                  post_q  <= 1'b0;
                  ready_q <= cw_mode;
               end
            end
         endcase
      end
   end

   assign ready_o  = ready_q;
   assign trig_o   = trig_q;
   assign sample_o = samp_q;
   assign post_o   = post_q;
   assign load_o   = post_q && (post_cnt < PW'(POST_LOAD));
endmodule

// File: rtl/tds_sequencer_chk.sv
module tds_sequencer_chk (
   input logic clk,
   input logic rst_n,
   input logic cw_mode,
   input logic ready_o,
   input logic trig_o,
   input logic sample_o,
   input logic post_o,
   input logic load_o
);
   AST_SAMPLE_TRIGGERED: assert property (@(posedge clk) disable iff (!rst_n) sample_o |-> trig_o); // R10
   AST_SAMPLE_POST_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({sample_o, post_o})); // R10
   AST_SAMPLE_AFTER_TRIG: assert property (@(posedge clk) disable iff (!rst_n) $rose(sample_o) |-> $past(trig_o)); // R4
   AST_POST_ENDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(post_o) |-> $fell(sample_o)); // R5
   AST_LOAD_IN_POST: assert property (@(posedge clk) disable iff (!rst_n) load_o |-> post_o); // R6
   AST_LOAD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) $fell(post_o) |-> (!$past(load_o) && !$past(load_o, 2))); // R6
   AST_READY_LOW_IN_POST: assert property (@(posedge clk) disable iff (!rst_n) post_o |-> !ready_o); // R7
   AST_CW_HOLDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n) (cw_mode && trig_o) |=> trig_o); // R9
endmodule

bind tds_sequencer tds_sequencer_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cw_mode(cw_mode), .ready_o(ready_o), .trig_o(trig_o),
   .sample_o(sample_o), .post_o(post_o), .load_o(load_o)
);

// File: tb/tds_sequencer_tb_top.sv
module tds_sequencer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trig_in = 1'b0;
   logic        rearm_in = 1'b0;
   logic [19:0] delay_val = 20'hFFFFF;
   logic        cw_mode = 1'b0;
   logic        ready_o, trig_o, sample_o, post_o, load_o;

   int checks = 0;
   int fails  = 0;
   int wd     = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   tds_sequencer dut_i (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .rearm_in(rearm_in),
      .delay_val(delay_val), .cw_mode(cw_mode), .ready_o(ready_o), .trig_o(trig_o),
      .sample_o(sample_o), .post_o(post_o), .load_o(load_o)
   );

   // edge-time monitor, sampled away from the active edge
   int cyc = 0;
   int tr = 0, sr = 0, sf = 0, pr = 0, pf = 0, lr = 0, lf = 0;
   int sr_cnt = 0, pf_cnt = 0;
   logic p_t = 0, p_s = 0, p_p = 0, p_l = 0;
   always @(negedge clk) begin
      cyc++;
      if (trig_o && !p_t) tr = cyc;
      if (sample_o && !p_s) begin sr = cyc; sr_cnt++; end
      if (!sample_o && p_s) sf = cyc;
      if (post_o && !p_p) pr = cyc;
      if (!post_o && p_p) begin pf = cyc; pf_cnt++; end
      if (load_o && !p_l) lr = cyc;
      if (!load_o && p_l) lf = cyc;
      p_t = trig_o; p_s = sample_o; p_p = post_o; p_l = load_o;
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic pulse_trig();
      @(negedge clk) trig_in = 1'b1;
      repeat (4) @(negedge clk);
      trig_in = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic pulse_rearm();
      @(negedge clk) rearm_in = 1'b1;
      repeat (4) @(negedge clk);
      rearm_in = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic wait_post();
      int n = pf_cnt;
      while (pf_cnt == n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1", "ready after reset", int'(ready_o), 1);
      chk("R1", "trig after reset", int'(trig_o), 0);
      chk("R1", "sample after reset", int'(sample_o), 0);
      chk("R1", "post after reset", int'(post_o), 0);
      chk("R1", "load after reset", int'(load_o), 0);
   endtask

   task automatic t_normal(input logic [19:0] v);
      int t0 = tr;
      delay_val = v;
      pulse_trig();
      wait_post();
      chk("R2", "trig latched by edge", int'(tr != t0), 1);
      chk("R3", "delay cycles", sr - tr, 32'h100000 - int'(v));
      chk("R5", "sample width", sf - sr, 510);
      chk("R5", "post rises as sample falls", pr - sf, 0);
      chk("R6", "post width", pf - pr, 4);
      chk("R6", "load starts with post", lr - pr, 0);
      chk("R6", "load width", lf - lr, 2);
      chk("R7", "ready after post", int'(ready_o), 0);
      chk("R7", "trig after post", int'(trig_o), 0);
      chk("R7", "sample after post", int'(sample_o), 0);
   endtask

   task automatic t_disarmed();
      int n = sr_cnt;
      pulse_trig();
      repeat (30) @(negedge clk);
      chk("R2", "trig while disarmed", int'(trig_o), 0);
      chk("R8", "no restart without rearm", sr_cnt - n, 0);
      chk("R8", "ready stays low", int'(ready_o), 0);
   endtask

   task automatic t_rearm();
      pulse_rearm();
      chk("R8", "ready after rearm", int'(ready_o), 1);
   endtask

   task automatic t_cw();
      int n;
      int p0;
      delay_val = 20'hFFFF0;
      cw_mode = 1'b1;
      pulse_trig();
      wait_post();
      p0 = pf;
      chk("R9", "ready back after post", int'(ready_o), 1);
      chk("R9", "trig held in cw", int'(trig_o), 1);
      n = sr_cnt;
      while (sr_cnt == n) @(posedge clk);
      @(negedge clk);
      chk("R9", "auto restart delay", sr - p0, 17);
      cw_mode = 1'b0;
      wait_post();
      chk("R7", "trig cleared after leaving cw", int'(trig_o), 0);
      chk("R7", "ready low after leaving cw", int'(ready_o), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_normal(20'hFFFFF);
      t_disarmed();
      t_rearm();
      t_normal(20'hFFFF0);
      t_rearm();
      t_normal(20'hFFC00);
      t_rearm();
      t_cw();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   always @(posedge clk) begin
      wd++;
      if (wd == 150000 && !done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule